// File: doc/BRIEF.md
# Page Program Data Loader

This block sits behind a serial flash command decoder while a page-program transaction is in progress. Once the decoder has recognised the program opcode it pulses `start_i`, then forwards every later serial data bit, already moved into the system clock domain, as a one-cycle `bit_stb_i` strobe with the value on `bit_i`, most significant bit first. The loader gathers the first three bytes as a 24-bit address and treats every byte after them as program data. Data bytes go into a page buffer that holds one byte for each position in the page. The write position starts at the low address byte and wraps inside the page, so a long burst keeps only the most recent bytes.

When the decoder reports the rising edge of chip select with `cs_rise_i`, the loader decides whether the program may go ahead. It accepts only when the address was complete, the edge came on a byte boundary, at least one data byte arrived, the write-enable latch is set and the page lies outside the protected window. An accepted transaction gives a one-cycle `commit_o` pulse with the page number and the count of valid bytes. Any other outcome gives a one-cycle `reject_o` pulse. A program engine then reads the buffered bytes and their per-position valid flags through a registered read port. Positions that were not loaded keep their valid flag clear, so the engine leaves those cells erased. Clearing the write-enable latch once the program has finished is the engine's task.

Top module: `page_loader`

## Requirements
- R1: After a synchronous reset, `commit_o` and `reject_o` are low and every buffer position reads with `rd_vld_o` = 0.
- R2: The first 24 bits after `start_i` form the address, MSB first. `commit_page_o` carries address bits 19..8, and address bits 23..20 have no effect.
- R3: Data byte k of a transaction is stored at buffer position (address bits 7..0 + k) mod 256, wrapping from 255 to 0. It reads back on `rd_data_o` with `rd_vld_o` = 1 one cycle after `rd_idx_i` is presented.
- R4: When more than 256 data bytes are sent, each position holds the last byte written to it, every position is valid and `commit_count_o` is 256.
- R5: A `cs_rise_i` on an accepted transaction gives `commit_o` high for exactly one cycle, in the cycle after the edge, with `reject_o` low, the page number and the data-byte count capped at 256.
- R6: A `cs_rise_i` that arrives while a byte is partly received (bit count not a multiple of 8) gives a one-cycle `reject_o` pulse and no commit.
- R7: A `cs_rise_i` with zero data bytes, including one that arrives before the address is complete, gives `reject_o` and no commit.
- R8: A `cs_rise_i` while `wen_i` is low gives `reject_o` and no commit.
- R9: When `prot_en_i` is high and the page lies in the inclusive range `prot_lo_i`..`prot_hi_i`, the transaction is rejected. A page just outside the range commits.
- R10: `start_i` clears every valid flag, so positions not loaded by the current transaction read with `rd_vld_o` = 0.
- R11: Bit strobes and `cs_rise_i` that arrive with no transaction open have no effect: no commit or reject pulse, and the buffer contents do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle pulse: program opcode recognised, transaction opens |
| bit_stb_i | input | 1 | One-cycle strobe: a serial bit was sampled |
| bit_i | input | 1 | Value of the sampled bit |
| cs_rise_i | input | 1 | One-cycle pulse: chip select went inactive |
| wen_i | input | 1 | Write-enable latch state |
| prot_en_i | input | 1 | Protected page window is active |
| prot_lo_i | input | 12 | First protected page |
| prot_hi_i | input | 12 | Last protected page |
| rd_idx_i | input | 8 | Buffer position to read |
| commit_o | output | 1 | One-cycle pulse: program accepted |
| reject_o | output | 1 | One-cycle pulse: transaction discarded |
| commit_page_o | output | 12 | Page number of the closed transaction |
| commit_count_o | output | 9 | Number of valid bytes, 1 to 256 on commit |
| rd_data_o | output | 8 | Buffered byte at the position read |
| rd_vld_o | output | 1 | Valid flag of the position read |

## Verification
The assertions assume that the decoder never pulses `cs_rise_i` or `start_i` in the same cycle as `bit_stb_i`, and that `start_i` and `cs_rise_i` never coincide. The rules for abort and idle behaviour are written on that basis. The stimulus keeps to this by giving every bit strobe a one-cycle pulse followed by an idle cycle, and by driving the chip-select and start pulses only between strobes. The protection window and write-enable inputs change only while no transaction is open, so the decision at `cs_rise_i` sees stable values.

// File: rtl/pl_pkg.sv
package pl_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } ph_e;
endpackage

// File: rtl/pl_deser.sv
module pl_deser #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic              bit_i,
  output logic              byte_stb_o,
  output logic [DATA_W-1:0] byte_o,
  output logic              mid_byte_o
);
  localparam int BC_W = $clog2(DATA_W);

  logic [BC_W-1:0]   bcnt_q;
  logic [DATA_W-1:0] sr_q;

  assign byte_stb_o = en_i && (bcnt_q == BC_W'(DATA_W - 1));
  assign byte_o     = {sr_q[DATA_W-2:0], bit_i};
  assign mid_byte_o = (bcnt_q != '0);

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      bcnt_q <= '0;
      sr_q   <= '0;
    end else if (en_i) begin
      sr_q <= byte_o;
      if (bcnt_q == BC_W'(DATA_W - 1)) bcnt_q <= '0;
      else                             bcnt_q <= bcnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pl_page_ram.sv
module pl_page_ram #(
  parameter int DATA_W = 8,
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [PAGE_W-1:0] wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [PAGE_W-1:0] rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int DEPTH = 1 << PAGE_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[wr_idx_i] <= wr_data_i;
    rd_data_o <= mem[rd_idx_i];
  end
endmodule

// File: rtl/pl_mask.sv
module pl_mask #(
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              set_i,
  input  logic [PAGE_W-1:0] set_idx_i,
  input  logic [PAGE_W-1:0] rd_idx_i,
  output logic              rd_vld_o
);
  localparam int DEPTH = 1 << PAGE_W;

  logic [DEPTH-1:0] vld_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i)  vld_q <= '0;
    else if (set_i)    vld_q[set_idx_i] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_vld_o <= 1'b0;
    else     rd_vld_o <= vld_q[rd_idx_i];
  end
endmodule

// File: rtl/pl_ctrl.sv
module pl_ctrl
  import pl_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 24,
  parameter int SIG_W  = 20,
  parameter int PAGE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start_i,
  input  logic                    cs_rise_i,
  input  logic                    byte_stb_i,
  input  logic [DATA_W-1:0]       byte_i,
  input  logic                    mid_byte_i,
  input  logic                    wen_i,
  input  logic                    prot_en_i,
  input  logic [SIG_W-PAGE_W-1:0] prot_lo_i,
  input  logic [SIG_W-PAGE_W-1:0] prot_hi_i,
  output logic                    active_o,
  output logic                    wr_en_o,
  output logic [PAGE_W-1:0]       wr_idx_o,
  output logic [DATA_W-1:0]       wr_data_o,
  output logic                    commit_o,
  output logic                    reject_o,
  output logic [SIG_W-PAGE_W-1:0] page_o,
  output logic [PAGE_W:0]         count_o
);
  localparam int DEPTH  = 1 << PAGE_W;
  localparam int CNT_W  = PAGE_W + 1;
  localparam int PG_W   = SIG_W - PAGE_W;
  localparam int ABYTES = ADDR_W / DATA_W;
  localparam int AB_W   = $clog2(ABYTES);

  ph_e               phase_q;
  logic [AB_W-1:0]   abyte_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] addr_nx;
  logic [PAGE_W-1:0] ptr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [PG_W-1:0]   cur_page;
  logic              prot_hit;
  logic              accept;

  assign addr_nx  = {addr_q[ADDR_W-DATA_W-1:0], byte_i};
  assign cur_page = addr_q[SIG_W-1:PAGE_W];
  assign prot_hit = prot_en_i && (cur_page >= prot_lo_i) && (cur_page <= prot_hi_i);
  assign accept   = (phase_q == PH_DATA) && !mid_byte_i && (cnt_q != '0)
                    && wen_i && !prot_hit;

  assign active_o  = (phase_q != PH_IDLE);
  assign wr_en_o   = byte_stb_i && (phase_q == PH_DATA) && !start_i && !cs_rise_i;
  assign wr_idx_o  = ptr_q;
  assign wr_data_o = byte_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= PH_IDLE;
      abyte_q  <= '0;
      addr_q   <= '0;
      ptr_q    <= '0;
      cnt_q    <= '0;
      commit_o <= 1'b0;
      reject_o <= 1'b0;
      page_o   <= '0;
      count_o  <= '0;
    end else begin
      commit_o <= 1'b0;
      reject_o <= 1'b0;
      if (start_i) begin
        phase_q <= PH_ADDR;
        abyte_q <= '0;
        addr_q  <= '0;
        cnt_q   <= '0;
      end else if (cs_rise_i && active_o) begin
        phase_q  <= PH_IDLE;
        commit_o <= accept;
        reject_o <= !accept;
        page_o   <= cur_page;
        count_o  <= cnt_q;
      end else if (byte_stb_i) begin
        case (phase_q)
          PH_ADDR: begin
            addr_q <= addr_nx;
            if (abyte_q == AB_W'(ABYTES - 1)) begin
              phase_q <= PH_DATA;
              ptr_q   <= addr_nx[PAGE_W-1:0];
            end else begin
              abyte_q <= abyte_q + 1'b1;
            end
          end
          PH_DATA: begin
            ptr_q <= ptr_q + 1'b1;
            if (cnt_q != CNT_W'(DEPTH)) cnt_q <= cnt_q + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  // R5
  commit_after_cs_chk: assert property (@(posedge clk) disable iff (rst)
    commit_o |-> $past(cs_rise_i));
  // R5
  outcome_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({commit_o, reject_o}));
  // R6
  midbyte_abort_chk: assert property (@(posedge clk) disable iff (rst)
    (cs_rise_i && active_o && mid_byte_i && !start_i) |=> (reject_o && !commit_o));
  // R7
  commit_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
    commit_o |-> (count_o != '0 && count_o <= CNT_W'(DEPTH)));
  // R8
  wen_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (cs_rise_i && active_o && !wen_i && !start_i) |=> !commit_o);
  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!active_o && !start_i) |=> ($stable(cnt_q) && !commit_o && !reject_o));
endmodule

// File: rtl/page_loader.sv
module page_loader #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 24,
  parameter int SIG_W  = 20,
  parameter int PAGE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start_i,
  input  logic                    bit_stb_i,
  input  logic                    bit_i,
  input  logic                    cs_rise_i,
  input  logic                    wen_i,
  input  logic                    prot_en_i,
  input  logic [SIG_W-PAGE_W-1:0] prot_lo_i,
  input  logic [SIG_W-PAGE_W-1:0] prot_hi_i,
  input  logic [PAGE_W-1:0]       rd_idx_i,
  output logic                    commit_o,
  output logic                    reject_o,
  output logic [SIG_W-PAGE_W-1:0] commit_page_o,
  output logic [PAGE_W:0]         commit_count_o,
  output logic [DATA_W-1:0]       rd_data_o,
  output logic                    rd_vld_o
);
  logic              active;
  logic              byte_stb;
  logic [DATA_W-1:0] byte_v;
  logic              mid_byte;
  logic              wr_en;
  logic [PAGE_W-1:0] wr_idx;
  logic [DATA_W-1:0] wr_data;

  pl_deser #(.DATA_W(DATA_W)) u_deser (
    .clk        (clk),
    .rst        (rst),
    .clr_i      (start_i),
    .en_i       (bit_stb_i && active && !start_i),
    .bit_i      (bit_i),
    .byte_stb_o (byte_stb),
    .byte_o     (byte_v),
    .mid_byte_o (mid_byte)
  );

  pl_ctrl #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SIG_W(SIG_W), .PAGE_W(PAGE_W)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .cs_rise_i  (cs_rise_i),
    .byte_stb_i (byte_stb),
    .byte_i     (byte_v),
    .mid_byte_i (mid_byte),
    .wen_i      (wen_i),
    .prot_en_i  (prot_en_i),
    .prot_lo_i  (prot_lo_i),
    .prot_hi_i  (prot_hi_i),
    .active_o   (active),
    .wr_en_o    (wr_en),
    .wr_idx_o   (wr_idx),
    .wr_data_o  (wr_data),
    .commit_o   (commit_o),
    .reject_o   (reject_o),
    .page_o     (commit_page_o),
    .count_o    (commit_count_o)
  );

  pl_page_ram #(.DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_ram (
    .clk       (clk),
    .we_i      (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_data_i (wr_data),
    .rd_idx_i  (rd_idx_i),
    .rd_data_o (rd_data_o)
  );

  pl_mask #(.PAGE_W(PAGE_W)) u_mask (
    .clk       (clk),
    .rst       (rst),
    .clr_i     (start_i),
    .set_i     (wr_en),
    .set_idx_i (wr_idx),
    .rd_idx_i  (rd_idx_i),
    .rd_vld_o  (rd_vld_o)
  );
endmodule

// File: tb/test_page_loader.sv
module test_page_loader;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0, bit_stb = 1'b0, bit_v = 1'b0, cs_rise = 1'b0;
  logic        wen = 1'b1, prot_en = 1'b0;
  logic [11:0] prot_lo = '0, prot_hi = '0;
  logic [7:0]  rd_idx = '0;
  logic        commit, reject, rd_vld;
  logic [11:0] cpage;
  logic [8:0]  ccount;
  logic [7:0]  rd_data;

  int checks = 0, errors = 0, events = 0;
  bit          sb_kind[$];
  logic [11:0] sb_page[$];
  logic [8:0]  sb_cnt[$];
  string       sb_tag[$];

  logic [7:0]  exp_data [256];
  bit          exp_vld  [256];
  logic [7:0]  exp_ptr;
  int          exp_cnt;
  logic [11:0] exp_page;

  always #10 clk = ~clk;

  page_loader i_page_loader (
    .clk(clk), .rst(rst), .start_i(start), .bit_stb_i(bit_stb), .bit_i(bit_v),
    .cs_rise_i(cs_rise), .wen_i(wen), .prot_en_i(prot_en), .prot_lo_i(prot_lo),
    .prot_hi_i(prot_hi), .rd_idx_i(rd_idx), .commit_o(commit), .reject_o(reject),
    .commit_page_o(cpage), .commit_count_o(ccount), .rd_data_o(rd_data), .rd_vld_o(rd_vld)
  );

  task automatic tick; @(negedge clk); endtask

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // monitor: pops scoreboard entries as outcomes appear
  always @(negedge clk) begin
    if (!rst && (commit || reject)) begin
      events++;
      if (sb_kind.size() == 0) begin
        chk(1'b0, "R11", "unexpected outcome", {commit, reject}, 0);
      end else begin
        bit k; logic [11:0] p; logic [8:0] c; string t;
        k = sb_kind.pop_front(); p = sb_page.pop_front();
        c = sb_cnt.pop_front();  t = sb_tag.pop_front();
        chk(commit == k && reject == !k, t, "commit/reject", {commit, reject}, {k, !k});
        if (k) begin
          chk(cpage == p, t, "page", cpage, p);
          chk(ccount == c, t, "count", ccount, c);
        end
      end
    end
  end

  task automatic pulse_bit(bit b);
    bit_v = b; bit_stb = 1'b1; tick; bit_stb = 1'b0; tick;
  endtask

  task automatic send_byte(logic [7:0] b);
    for (int i = 7; i >= 0; i--) pulse_bit(b[i]);
  endtask

  task automatic begin_txn(logic [23:0] a);
    start = 1'b1; tick; start = 1'b0;
    for (int i = 0; i < 256; i++) exp_vld[i] = 1'b0;
    exp_cnt = 0; exp_ptr = a[7:0]; exp_page = a[19:8];
    send_byte(a[23:16]); send_byte(a[15:8]); send_byte(a[7:0]);
  endtask

  task automatic data_byte(logic [7:0] b);
    send_byte(b);
    exp_data[exp_ptr] = b; exp_vld[exp_ptr] = 1'b1;
    exp_ptr = exp_ptr + 8'd1;
    if (exp_cnt < 256) exp_cnt++;
  endtask

  task automatic end_txn(bit ok, string tag);
    sb_kind.push_back(ok); sb_page.push_back(exp_page);
    sb_cnt.push_back(9'(exp_cnt)); sb_tag.push_back(tag);
    cs_rise = 1'b1; tick; cs_rise = 1'b0; tick; tick;
  endtask

  task automatic check_pos(logic [7:0] idx, string tag);
    rd_idx = idx; tick;
    chk(rd_vld == exp_vld[idx], tag, $sformatf("valid@%0h", idx), rd_vld, exp_vld[idx]);
    if (exp_vld[idx])
      chk(rd_data == exp_data[idx], tag, $sformatf("data@%0h", idx), rd_data, exp_data[idx]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int ev0;
    for (int i = 0; i < 256; i++) begin exp_vld[i] = 1'b0; exp_data[i] = '0; end
    repeat (3) tick;
    rst = 1'b0;
    tick;
    // R1 reset state
    chk(!commit && !reject, "R1", "outputs after reset", {commit, reject}, 0);
    check_pos(8'h00, "R1");
    check_pos(8'h80, "R1");

    // R2 R3 R5: upper nibble ignored, page 345, offset 10
    begin_txn(24'hA34510);
    data_byte(8'h11); data_byte(8'h22); data_byte(8'h33); data_byte(8'h44);
    end_txn(1'b1, "R5");
    check_pos(8'h10, "R3"); check_pos(8'h13, "R3");
    check_pos(8'h0F, "R10"); check_pos(8'h14, "R10");

    // R3 wrap inside page, R10 old flags cleared
    begin_txn(24'h0012FE);
    data_byte(8'hC1); data_byte(8'hC2); data_byte(8'hC3);
    end_txn(1'b1, "R2");
    check_pos(8'hFE, "R3"); check_pos(8'hFF, "R3"); check_pos(8'h00, "R3");
    check_pos(8'h10, "R10");

    // R4 overflow: 260 bytes from offset 0
    begin_txn(24'h000200);
    for (int i = 0; i < 260; i++) data_byte(8'(i) + ((i >= 256) ? 8'h80 : 8'h00));
    end_txn(1'b1, "R4");
    check_pos(8'h00, "R4"); check_pos(8'h03, "R4");
    check_pos(8'h04, "R4"); check_pos(8'hFF, "R4");

    // R6 chip select mid-byte
    begin_txn(24'h000700);
    data_byte(8'h5A); data_byte(8'hA5);
    pulse_bit(1'b1); pulse_bit(1'b0); pulse_bit(1'b1);
    end_txn(1'b0, "R6");

    // R7 no data bytes; and during address
    begin_txn(24'h000800);
    end_txn(1'b0, "R7");
    start = 1'b1; tick; start = 1'b0;
    send_byte(8'h00); send_byte(8'h09);
    end_txn(1'b0, "R7");

    // R8 write enable low
    wen = 1'b0;
    begin_txn(24'h000A00);
    data_byte(8'h77);
    end_txn(1'b0, "R8");
    wen = 1'b1;

    // R9 protected window 100..1FF inclusive
    prot_en = 1'b1; prot_lo = 12'h100; prot_hi = 12'h1FF;
    begin_txn(24'h015020);
    data_byte(8'h01);
    end_txn(1'b0, "R9");
    begin_txn(24'h01FF00);
    data_byte(8'h02);
    end_txn(1'b0, "R9");
    begin_txn(24'h020000);
    data_byte(8'h03); data_byte(8'h04);
    end_txn(1'b1, "R9");
    prot_en = 1'b0;

    // R11 idle strobes and chip-select edge
    ev0 = events;
    send_byte(8'hEE); send_byte(8'hDD);
    cs_rise = 1'b1; tick; cs_rise = 1'b0;
    repeat (4) tick;
    chk(events == ev0, "R11", "outcomes while idle", events - ev0, 0);
    check_pos(8'h00, "R11"); check_pos(8'h01, "R11"); check_pos(8'h02, "R11");

    repeat (4) tick;
    chk(sb_kind.size() == 0, "R5", "pending outcomes", sb_kind.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule